// File: doc/BRIEF.md
# Zero-Terminated Segment Load Sequencer

This block runs one unit-stride segment load that ends as soon as an active element reads back as zero. A start pulse captures the whole setup: base address, element width code, memory access width code, register group size code, field count code, vector length, maximum vector length, destination register, one mask bit per element and a sign-extension select. The block then issues one memory read per field of every element, in address order. Each read is extended to 64 bits, cut to the element width, and written into the register file at the slot that the striped layout gives.

Elements at or above the vector length, and elements whose mask bit is clear, are still read from memory, but they write zero. The first active element whose memory value is zero also writes its slot. The instruction then ends at once: the done pulse carries a valid strobe and the index of that element as the new vector length. If no such element is met, done rises after the last field of the last element and no new length is reported. A setup that is not allowed ends at once with an illegal flag and touches neither memory nor registers.

Top module: `zterm_seg_load`

## Requirements
- R1: The setup is illegal when the element width code (0=8, 1=16, 2=32, 3=64 bits, 4..7 reserved) is above 3 or below the memory width code (0=1, 1=2, 2=4, 3=8 bytes). An illegal start gives one cycle with `done` and `illegal` high and no memory request or register write.
- R2: The setup is also illegal when (field code + 1) shifted left by the group size code (0..3 meaning 1, 2, 4, 8 registers) is more than 8.
- R3: The read for element i, field f is at base + (i*(field code+1) + f) * memory bytes. Reads go in ascending order of that offset. While `mem_ack` is low, the request and its address stay stable.
- R4: With S = SLEN/width, V = VLEN/width, G = 2^group code and L = G*S, element i writes register vd + f*G + (i mod L)/S at slot (i/L)*S + (i mod S).
- R5: An active element (i < vl and mask bit i set) writes the memory value, sign-extended when `load_signed` is 1 and zero-extended otherwise, cut to the element width. An inactive element writes zero. A write follows the acknowledge of its read.
- R6: When an active element reads a memory value of zero, its write is the last access. `done` and `vl_upd_valid` then rise together, and `vl_upd` holds that element index.
- R7: A start with vl equal to zero gives `done` alone, with no access and no length update.
- R8: With no early stop, every field of every element up to vlmax is read and written. `done` is a one-cycle pulse with `vl_upd_valid` low.
- R9: A start pulse while an instruction is running is ignored.
- R10: Reset, applied at any time, drops every request, write and done output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Captures the setup and begins the instruction |
| base_addr | input | ADDR_W | Base byte address |
| sew_code | input | 3 | Element width code |
| mem_w_code | input | 2 | Memory access width code |
| lmul_code | input | 2 | Register group size code |
| nf_code | input | 3 | Field count minus one |
| vl_in | input | IDX_W | Vector length |
| vlmax_in | input | IDX_W | Element loop bound |
| vd_in | input | REG_W | First destination register |
| mask_in | input | MAX_ELEMS | Per-element enable bits |
| load_signed | input | 1 | 1 selects sign extension |
| mem_req | output | 1 | Read request |
| mem_addr | output | ADDR_W | Read byte address |
| mem_size | output | 2 | Read width code |
| mem_ack | input | 1 | Read data valid, completes the request |
| mem_rdata | input | 64 | Read data, low bytes significant |
| rf_we | output | 1 | Register write strobe |
| rf_reg | output | REG_W | Register number |
| rf_elem | output | ELEM_W | Element slot in the register |
| rf_sew | output | 2 | Width code of the write |
| rf_data | output | 64 | Write data |
| done | output | 1 | Instruction finished |
| illegal | output | 1 | Setup refused, with done |
| vl_upd_valid | output | 1 | New vector length valid, with done |
| vl_upd | output | IDX_W | New vector length |

## Verification
A table of setups drives the main function with each element width and memory width, with group sizes 1 to 8 and field counts 1 to 4, and with all-set, alternating and all-clear masks. For every run, a model of the address formula and the striped slot mapping checks each read and each write, so a wrong shift or group offset shows up at once. The zero word is placed on an active element (which must stop the run), on a masked element, on a tail element past vl, and on the first and last active element; together these show whether the stop depends on the activity rule. Directed runs add illegal setups, a zero length, a start pulse sent mid-run and a reset sent mid-run.

// File: rtl/zterm_pkg.sv
package zterm_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_LOAD,
      ST_WRITE,
      ST_FIN
   } seq_state_e;

   // Low-byte mask for a width code 0..3 (1, 2, 4, 8 bytes).
   function automatic logic [63:0] width_mask(input logic [1:0] code);
      logic [63:0] m;
      case (code)
         2'd0:    m = 64'h0000_0000_0000_00FF;
         2'd1:    m = 64'h0000_0000_0000_FFFF;
         2'd2:    m = 64'h0000_0000_FFFF_FFFF;
         default: m = 64'hFFFF_FFFF_FFFF_FFFF;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/zterm_legal.sv
module zterm_legal (
   input  logic [2:0] sew_code,
   input  logic [1:0] mem_w_code,
   input  logic [1:0] lmul_code,
   input  logic [2:0] nf_code,
   output logic       legal
);
   logic       width_ok;
   logic [6:0] group_regs;

   assign width_ok   = !sew_code[2] && (sew_code[1:0] >= mem_w_code);
   assign group_regs = (7'({4'b0, nf_code}) + 7'd1) << lmul_code;
   assign legal      = width_ok && (group_regs <= 7'd8);
endmodule

// File: rtl/zterm_extend.sv
module zterm_extend
   import zterm_pkg::*;
#(
   parameter bit SIGN_EN = 1'b1
) (
   input  logic [63:0] raw,
   input  logic [1:0]  mem_w_code,
   input  logic        load_signed,
   input  logic [1:0]  sew_code,
   output logic [63:0] value,
   output logic        is_zero
);
   logic [63:0] mem_mask;
   logic [63:0] raw_m;
   logic [63:0] ext;
   logic        top_bit;

   assign mem_mask = width_mask(mem_w_code);
   assign raw_m    = raw & mem_mask;
   assign is_zero  = (raw_m == 64'd0);

   always_comb begin
      case (mem_w_code)
         2'd0:    top_bit = raw[7];
         2'd1:    top_bit = raw[15];
         2'd2:    top_bit = raw[31];
         default: top_bit = raw[63];
      endcase
   end

   generate
      if (SIGN_EN) begin : g_sext
         assign ext = (load_signed && top_bit) ? (raw_m | ~mem_mask) : raw_m;
      end else begin : g_zext
         logic unused_sel;
         assign unused_sel = load_signed ^ top_bit;
         assign ext = raw_m;
      end
   endgenerate

   assign value = ext & width_mask(sew_code);
endmodule

// File: rtl/zterm_slot_map.sv
module zterm_slot_map #(
   parameter int SLEN   = 64,
   parameter int IDX_W  = 8,
   parameter int REG_W  = 5,
   parameter int ELEM_W = 4
) (
   input  logic [IDX_W-1:0]  elem,
   input  logic [2:0]        fld,
   input  logic [1:0]        sew_code,
   input  logic [1:0]        lmul_code,
   input  logic [REG_W-1:0]  vd,
   output logic [REG_W-1:0]  rf_reg,
   output logic [ELEM_W-1:0] rf_elem
);
   localparam int SLEN_LOG = $clog2(SLEN);

   logic [4:0]       sh_strip;
   logic [4:0]       sh_lane;
   logic [IDX_W-1:0] in_strip;
   logic [IDX_W-1:0] grp_idx;
   logic [IDX_W-1:0] strip_no;
   logic [IDX_W-1:0] slot;
   logic [5:0]       fld_off;
   logic             unused_hi;

   // log2 of elements per strip, and per strip times group size
   assign sh_strip = 5'(SLEN_LOG - 3) - {3'b0, sew_code};
   assign sh_lane  = sh_strip + {3'b0, lmul_code};

   assign in_strip = elem & ((IDX_W'(1) << sh_strip) - IDX_W'(1));
   assign grp_idx  = (elem >> sh_strip) & ((IDX_W'(1) << lmul_code) - IDX_W'(1));
   assign strip_no = elem >> sh_lane;
   assign slot     = (strip_no << sh_strip) | in_strip;
   assign fld_off  = {3'b0, fld} << lmul_code;

   assign rf_reg    = vd + REG_W'(fld_off) + REG_W'(grp_idx);
   assign rf_elem   = slot[ELEM_W-1:0];
   assign unused_hi = ^slot[IDX_W-1:ELEM_W];
endmodule

// File: rtl/zterm_seg_load.sv
module zterm_seg_load
   import zterm_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int VLEN      = 128,
   parameter int SLEN      = 64,
   parameter int NREG      = 32,
   parameter bit SIGN_EN   = 1'b1,
   localparam int MAX_ELEMS = VLEN,
   localparam int IDX_W     = $clog2(MAX_ELEMS) + 1,
   localparam int EIDX_W    = $clog2(MAX_ELEMS),
   localparam int REG_W     = $clog2(NREG),
   localparam int ELEM_W    = $clog2(VLEN / 8)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [ADDR_W-1:0]    base_addr,
   input  logic [2:0]           sew_code,
   input  logic [1:0]           mem_w_code,
   input  logic [1:0]           lmul_code,
   input  logic [2:0]           nf_code,
   input  logic [IDX_W-1:0]     vl_in,
   input  logic [IDX_W-1:0]     vlmax_in,
   input  logic [REG_W-1:0]     vd_in,
   input  logic [MAX_ELEMS-1:0] mask_in,
   input  logic                 load_signed,
   output logic                 mem_req,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic [1:0]           mem_size,
   input  logic                 mem_ack,
   input  logic [63:0]          mem_rdata,
   output logic                 rf_we,
   output logic [REG_W-1:0]     rf_reg,
   output logic [ELEM_W-1:0]    rf_elem,
   output logic [1:0]           rf_sew,
   output logic [63:0]          rf_data,
   output logic                 done,
   output logic                 illegal,
   output logic                 vl_upd_valid,
   output logic [IDX_W-1:0]     vl_upd
);
   generate
      if (SLEN < 64 || SLEN > VLEN || (SLEN & (SLEN - 1)) != 0 ||
          (VLEN & (VLEN - 1)) != 0 || NREG < 8 || ADDR_W < 8) begin : g_bad_cfg
         $error("zterm_seg_load: unsupported parameter set");
      end
   endgenerate

   seq_state_e           state;
   logic [ADDR_W-1:0]    base_q;
   logic [ADDR_W-1:0]    off_q;
   logic [1:0]           sew_q;
   logic [1:0]           mw_q;
   logic [1:0]           lmul_q;
   logic [2:0]           nf_q;
   logic [IDX_W-1:0]     cfg_vl_q;
   logic [IDX_W-1:0]     vlmax_q;
   logic [REG_W-1:0]     vd_q;
   logic [MAX_ELEMS-1:0] mask_q;
   logic                 sgn_q;
   logic [IDX_W-1:0]     elem_q;
   logic [2:0]           fld_q;
   logic [63:0]          data_q;
   logic                 zero_q;
   logic                 stop_q;
   logic                 ill_q;

   logic                 setup_ok;
   logic [63:0]          ext_val;
   logic                 ext_zero;
   logic                 elem_act;
   logic                 last_fld;
   logic                 last_elem;

   zterm_legal u_legal (
      .sew_code   (sew_code),
      .mem_w_code (mem_w_code),
      .lmul_code  (lmul_code),
      .nf_code    (nf_code),
      .legal      (setup_ok)
   );

   zterm_extend #(.SIGN_EN(SIGN_EN)) u_ext (
      .raw         (mem_rdata),
      .mem_w_code  (mw_q),
      .load_signed (sgn_q),
      .sew_code    (sew_q),
      .value       (ext_val),
      .is_zero     (ext_zero)
   );

   zterm_slot_map #(
      .SLEN   (SLEN),
      .IDX_W  (IDX_W),
      .REG_W  (REG_W),
      .ELEM_W (ELEM_W)
   ) u_map (
      .elem      (elem_q),
      .fld       (fld_q),
      .sew_code  (sew_q),
      .lmul_code (lmul_q),
      .vd        (vd_q),
      .rf_reg    (rf_reg),
      .rf_elem   (rf_elem)
   );

   assign elem_act  = (elem_q < cfg_vl_q) && mask_q[elem_q[EIDX_W-1:0]];
   assign last_fld  = (fld_q == nf_q);
   assign last_elem = (elem_q == vlmax_q - IDX_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         base_q   <= '0;
         off_q    <= '0;
         sew_q    <= '0;
         mw_q     <= '0;
         lmul_q   <= '0;
         nf_q     <= '0;
         cfg_vl_q <= '0;
         vlmax_q  <= '0;
         vd_q     <= '0;
         mask_q   <= '0;
         sgn_q    <= 1'b0;
         elem_q   <= '0;
         fld_q    <= '0;
         data_q   <= '0;
         zero_q   <= 1'b0;
         stop_q   <= 1'b0;
         ill_q    <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start) begin
                  base_q   <= base_addr;
                  off_q    <= '0;
                  sew_q    <= sew_code[1:0];
                  mw_q     <= mem_w_code;
                  lmul_q   <= lmul_code;
                  nf_q     <= nf_code;
                  cfg_vl_q <= vl_in;
                  vlmax_q  <= vlmax_in;
                  vd_q     <= vd_in;
                  mask_q   <= mask_in;
                  sgn_q    <= load_signed;
                  elem_q   <= '0;
                  fld_q    <= '0;
                  stop_q   <= 1'b0;
                  ill_q    <= !setup_ok;
                  if (!setup_ok || vl_in == '0 || vlmax_in == '0)
                     state <= ST_FIN;
                  else
                     state <= ST_LOAD;
               end
            end
            ST_LOAD: begin
               if (mem_ack) begin
                  data_q <= ext_val;
                  zero_q <= ext_zero;
                  off_q  <= off_q + (ADDR_W'(1) << mw_q);
                  state  <= ST_WRITE;
               end
            end
            ST_WRITE: begin
               if (elem_act && zero_q) begin
                  stop_q <= 1'b1;
                  state  <= ST_FIN;
               end else if (last_fld) begin
                  fld_q <= '0;
                  if (last_elem) begin
                     state <= ST_FIN;
                  end else begin
                     elem_q <= elem_q + IDX_W'(1);
                     state  <= ST_LOAD;
                  end
               end else begin
                  fld_q <= fld_q + 3'd1;
                  state <= ST_LOAD;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign mem_req      = (state == ST_LOAD);
   assign mem_addr     = base_q + off_q;
   assign mem_size     = mw_q;
   assign rf_we        = (state == ST_WRITE);
   assign rf_sew       = sew_q;
   assign rf_data      = elem_act ? data_q : 64'd0;
   assign done         = (state == ST_FIN);
   assign illegal      = done && ill_q;
   assign vl_upd_valid = done && stop_q;
   assign vl_upd       = vl_upd_valid ? elem_q : '0;
endmodule

// File: rtl/zterm_seg_load_chk.sv
module zterm_seg_load_chk #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic              mem_ack,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              rf_we,
   input logic              done,
   input logic              illegal,
   input logic              vl_upd_valid,
   input logic [IDX_W-1:0]  vl_upd,
   input logic [IDX_W-1:0]  cfg_vl_q
);
   p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

   p_we_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> $past(mem_req && mem_ack));

   p_upd_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      vl_upd_valid |-> done);

   p_upd_below_vl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      vl_upd_valid |-> (vl_upd < cfg_vl_q));

   p_illegal_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (done && !vl_upd_valid));

   p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!mem_req && !rf_we));

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

bind zterm_seg_load zterm_seg_load_chk #(
   .ADDR_W (ADDR_W),
   .IDX_W  (IDX_W)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .mem_req      (mem_req),
   .mem_ack      (mem_ack),
   .mem_addr     (mem_addr),
   .rf_we        (rf_we),
   .done         (done),
   .illegal      (illegal),
   .vl_upd_valid (vl_upd_valid),
   .vl_upd       (vl_upd),
   .cfg_vl_q     (cfg_vl_q)
);

// File: tb/zterm_seg_load_tb_top.sv
module zterm_seg_load_tb_top;
   localparam int VLEN = 128;
   localparam int SLEN = 64;
   localparam int NE   = 128;
   localparam logic [31:0] BASE = 32'h0000_1000;

   typedef struct packed {
      logic [2:0]  sew;
      logic [1:0]  mw;
      logic [1:0]  lmul;
      logic [2:0]  nfe;
      logic [7:0]  vl;
      logic [7:0]  vlmax;
      logic [4:0]  vd;
      logic        sgn;
      logic [31:0] zaddr;
      logic [1:0]  msel;
      logic        e_ill;
      logic        e_upd;
      logic [7:0]  e_vl;
   } vec_t;

   // msel: 0 all active, 1 even elements active, 2 none active
   localparam vec_t VECS [12] = '{
      '{3'd0, 2'd0, 2'd0, 3'd0, 8'd16, 8'd16, 5'd2,  1'b0, 32'h0,    2'd0, 1'b0, 1'b0, 8'd0},
      '{3'd2, 2'd1, 2'd1, 3'd1, 8'd6,  8'd8,  5'd8,  1'b1, 32'h1012, 2'd1, 1'b0, 1'b1, 8'd4},
      '{3'd2, 2'd1, 2'd1, 3'd1, 8'd6,  8'd8,  5'd8,  1'b1, 32'h100C, 2'd1, 1'b0, 1'b0, 8'd0},
      '{3'd3, 2'd3, 2'd0, 3'd2, 8'd2,  8'd2,  5'd4,  1'b0, 32'h1000, 2'd0, 1'b0, 1'b1, 8'd0},
      '{3'd1, 2'd0, 2'd3, 3'd0, 8'd40, 8'd64, 5'd16, 1'b1, 32'h1027, 2'd0, 1'b0, 1'b1, 8'd39},
      '{3'd1, 2'd0, 2'd3, 3'd0, 8'd40, 8'd64, 5'd16, 1'b1, 32'h102D, 2'd0, 1'b0, 1'b0, 8'd0},
      '{3'd0, 2'd1, 2'd0, 3'd0, 8'd16, 8'd16, 5'd0,  1'b0, 32'h0,    2'd0, 1'b1, 1'b0, 8'd0},
      '{3'd2, 2'd0, 2'd2, 3'd3, 8'd16, 8'd16, 5'd0,  1'b0, 32'h0,    2'd0, 1'b1, 1'b0, 8'd0},
      '{3'd4, 2'd0, 2'd0, 3'd0, 8'd16, 8'd16, 5'd0,  1'b0, 32'h0,    2'd0, 1'b1, 1'b0, 8'd0},
      '{3'd0, 2'd0, 2'd0, 3'd0, 8'd0,  8'd16, 5'd0,  1'b0, 32'h1000, 2'd0, 1'b0, 1'b0, 8'd0},
      '{3'd2, 2'd2, 2'd0, 3'd0, 8'd4,  8'd4,  5'd6,  1'b0, 32'h1000, 2'd2, 1'b0, 1'b0, 8'd0},
      '{3'd3, 2'd2, 2'd1, 3'd3, 8'd3,  8'd4,  5'd24, 1'b1, 32'h102C, 2'd0, 1'b0, 1'b1, 8'd2}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [31:0]   base_addr = '0;
   logic [2:0]    sew_code = '0;
   logic [1:0]    mem_w_code = '0;
   logic [1:0]    lmul_code = '0;
   logic [2:0]    nf_code = '0;
   logic [7:0]    vl_in = '0;
   logic [7:0]    vlmax_in = '0;
   logic [4:0]    vd_in = '0;
   logic [NE-1:0] mask_in = '0;
   logic          load_signed = 1'b0;
   logic          mem_req;
   logic [31:0]   mem_addr;
   logic [1:0]    mem_size;
   logic          mem_ack;
   logic [63:0]   mem_rdata;
   logic          rf_we;
   logic [4:0]    rf_reg;
   logic [3:0]    rf_elem;
   logic [1:0]    rf_sew;
   logic [63:0]   rf_data;
   logic          done;
   logic          illegal;
   logic          vl_upd_valid;
   logic [7:0]    vl_upd;

   logic [31:0]   zaddr = 32'hFFFF_FFFF;
   logic [2:0]    gcnt = '0;
   int            n_checks = 0;
   int            n_errors = 0;

   always #5 clk = ~clk;
   always @(posedge clk) gcnt <= gcnt + 3'd1;

   function automatic logic [63:0] mem_word(input logic [31:0] a);
      logic [63:0] w;
      for (int k = 0; k < 8; k++)
         w[k*8 +: 8] = ((a[7:0] + 8'(k)) ^ 8'h80) | 8'h01;
      return w;
   endfunction

   function automatic logic [63:0] low_mask(input int bytes);
      return (bytes >= 8) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (bytes * 8)) - 64'd1);
   endfunction

   assign mem_ack   = mem_req && (gcnt != 3'd2);
   assign mem_rdata = (mem_addr == zaddr) ? 64'd0 : mem_word(mem_addr);

   zterm_seg_load dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
      .sew_code(sew_code), .mem_w_code(mem_w_code), .lmul_code(lmul_code),
      .nf_code(nf_code), .vl_in(vl_in), .vlmax_in(vlmax_in), .vd_in(vd_in),
      .mask_in(mask_in), .load_signed(load_signed),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_size(mem_size),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .rf_we(rf_we), .rf_reg(rf_reg), .rf_elem(rf_elem), .rf_sew(rf_sew),
      .rf_data(rf_data), .done(done), .illegal(illegal),
      .vl_upd_valid(vl_upd_valid), .vl_upd(vl_upd)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic check_idle(input string req);
      chk(!mem_req, req, "mem_req idle", longint'(mem_req), 0);
      chk(!rf_we, req, "rf_we idle", longint'(rf_we), 0);
      chk(!done, req, "done idle", longint'(done), 0);
      chk(!vl_upd_valid, req, "vl_upd_valid idle", longint'(vl_upd_valid), 0);
   endtask

   // Runs one setup, checks every access against the model.
   // poke > 0 sends a second start pulse (other base) that many cycles in.
   task automatic run_vec(input vec_t v, input int poke);
      int nf, ei, efn, cyc, sewb, mbytes, grp, per_s, per_v, per_l;
      int sidx, istr, linx, vinx, exp_reg, exp_el;
      bit stopped, seen_done, act;
      logic [31:0]  last_a;
      logic [63:0]  raw, ext, exp_d;
      nf = int'(v.nfe) + 1;
      ei = 0; efn = 0; stopped = 0; seen_done = 0; last_a = '0;
      sewb = 8 << v.sew[1:0];
      mbytes = 1 << v.mw;
      grp = 1 << v.lmul;
      per_s = SLEN / sewb; per_v = VLEN / sewb; per_l = grp * per_s;
      @(negedge clk);
      base_addr = BASE; sew_code = v.sew; mem_w_code = v.mw; lmul_code = v.lmul;
      nf_code = v.nfe; vl_in = v.vl; vlmax_in = v.vlmax; vd_in = v.vd;
      load_signed = v.sgn; zaddr = v.zaddr;
      mask_in = (v.msel == 2'd0) ? {NE{1'b1}} : (v.msel == 2'd1) ? {(NE/2){2'b01}} : '0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (cyc = 1; cyc < 4000; cyc++) begin
         if (poke > 0 && cyc == poke) begin
            base_addr = 32'h0000_8000; start = 1'b1;
         end else begin
            start = 1'b0;
            base_addr = BASE;
         end
         if (stopped && (rf_we || (mem_req && mem_ack)))
            chk(1'b0, "R6", "access after stop", longint'(ei), 0);
         if (mem_req && mem_ack && !stopped) begin
            chk(mem_addr == BASE + 32'((ei * nf + efn) * mbytes), "R3", "address",
                longint'(mem_addr), longint'(BASE + 32'((ei * nf + efn) * mbytes)));
            chk(mem_size == v.mw, "R3", "size", longint'(mem_size), longint'(v.mw));
            last_a = mem_addr;
         end
         if (rf_we && !stopped) begin
            sidx = ei / per_l; istr = ei % per_s; linx = (ei % per_l) / per_s;
            vinx = linx * per_v + sidx * per_s + istr;
            exp_reg = (int'(v.vd) + efn * grp + vinx / per_v) % 32;
            exp_el  = vinx % per_v;
            chk(rf_reg == 5'(exp_reg), "R4", "register", longint'(rf_reg), longint'(exp_reg));
            chk(rf_elem == 4'(exp_el), "R4", "slot", longint'(rf_elem), longint'(exp_el));
            chk(rf_sew == v.sew[1:0], "R4", "write width", longint'(rf_sew), longint'(v.sew[1:0]));
            raw = ((last_a == v.zaddr) ? 64'd0 : mem_word(last_a)) & low_mask(mbytes);
            ext = (v.sgn && raw[mbytes*8-1]) ? (raw | ~low_mask(mbytes)) : raw;
            act = (ei < int'(v.vl)) && mask_in[ei];
            exp_d = act ? (ext & low_mask(sewb / 8)) : 64'd0;
            chk(rf_data == exp_d, "R5", "write data", longint'(rf_data), longint'(exp_d));
            if (act && raw == 64'd0) begin
               stopped = 1;
            end else if (efn == nf - 1) begin
               efn = 0; ei++;
            end else begin
               efn++;
            end
         end
         if (done) begin
            seen_done = 1;
            break;
         end
         @(negedge clk);
      end
      start = 1'b0;
      base_addr = BASE;
      chk(seen_done, "R8", "done reached", longint'(seen_done), 1);
      chk(illegal == v.e_ill, v.e_ill ? "R1" : "R2", "illegal flag",
          longint'(illegal), longint'(v.e_ill));
      chk(vl_upd_valid == v.e_upd, "R6", "update strobe",
          longint'(vl_upd_valid), longint'(v.e_upd));
      chk(stopped == v.e_upd, "R6", "model stop", longint'(stopped), longint'(v.e_upd));
      if (v.e_upd)
         chk(vl_upd == v.e_vl, "R6", "new length", longint'(vl_upd), longint'(v.e_vl));
      else if (v.e_ill || v.vl == 8'd0)
         chk(ei == 0 && efn == 0, "R7", "no access", longint'(ei), 0);
      else
         chk(ei == int'(v.vlmax), "R8", "all elements", longint'(ei), longint'(v.vlmax));
      @(negedge clk);
      chk(!done && !vl_upd_valid, "R8", "done single pulse", longint'(done), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check_idle("R10");
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R10");

      for (int i = 0; i < 12; i++) run_vec(VECS[i], 0);

      // R9: a second start mid-run must not disturb the address stream
      run_vec(VECS[0], 6);

      // R10: reset in the middle of a run
      @(negedge clk);
      sew_code = 3'd0; mem_w_code = 2'd0; lmul_code = 2'd0; nf_code = 3'd0;
      vl_in = 8'd16; vlmax_in = 8'd16; mask_in = {NE{1'b1}}; zaddr = 32'hFFFF_FFFF;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (7) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check_idle("R10");
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check_idle("R10");
      run_vec(VECS[1], 0);

      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end
endmodule